// File: doc/BRIEF.md
# Current-Loop DAC Serial Front End

This block is the digital side of a serial current-output converter. A host sends 24-bit frames, most significant bit first, on a serial data pin that is sampled on the rising edge of a serial clock. A rising edge on a latch pin moves the received frame into the register its top byte addresses. The data register sets the output code. The control register sets the output range and turns on pass-through mode. The block drives the output code, the range selection and the nominal loop current in microamps that a downstream current source should produce.

The same 24-bit shift path is also used for reading registers back. A read command frame selects a register. During the next frame, that register is shifted out on the serial output, preceded by eight filler bits. In pass-through mode, the serial output repeats the incoming stream 24 clocks later, so several converters can share one data line and one latch strobe.

All serial pins are resynchronised into a single system clock. An asynchronous clear input forces the code to the bottom of the active range while it is held. A fault input is passed straight through to an output and can also be read back as status.

Top module: `loop_dac_front`

## Requirements
- R1: After power-on reset the output code is 0, the range field is 3'b000, the loop current is 0 µA, pass-through mode is off and the serial output is disabled (sdo_oe_o low).
- R2: Frames are 24 bits shifted in MSB first on rising serial-clock edges. On a rising latch edge, a frame whose bits 23:16 equal 8'h01 loads bits 15:(16-DATA_W) into the data register, and code_o takes that value.
- R3: On a latch edge, a frame with bits 23:16 equal to 8'h55 writes the control register: bits 2:0 become range_o and bit 3 enables pass-through mode.
- R4: A frame whose bits 23:16 equal 8'h00 (no-op), or any value other than 8'h01, 8'h02 or 8'h55, changes no register.
- R5: On a latch edge, a frame with bits 23:16 equal to 8'h02 starts a readback. sdo_oe_o goes high, and sdo_o then carries the 24-bit word {8'h00, value}, MSB first, advancing one bit on each falling serial-clock edge. The value is chosen by bits 1:0 of the read frame: 00 gives status (bit 0 = fault_i), 01 gives the data register left-justified in 16 bits, 10 gives the control register {12'b0, pass-through, range}, and 11 gives zero.
- R6: The next latch edge ends a readback, and sdo_oe_o goes low, unless that frame is itself a read command or pass-through mode is on.
- R7: With pass-through on and no readback active, sdo_oe_o is high. At each falling serial-clock edge, sdo_o takes the bit that was clocked in 24 rising edges earlier (0 before any such bit exists).
- R8: While clear_i is high, code_o is 0 with no clock needed, and the loop current is the bottom of the range: 4000 µA for range 3'b101, 0 µA for the others. The data register is kept, and its code returns when clear_i falls.
- R9: loop_ua_o = low + floor(code16 × span / 65536), where code16 is the code left-justified in 16 bits. The pairs (low, span) are (4000, 16000) for range 3'b101, (0, 20000) for 3'b110 and (0, 24000) for 3'b111. Every other range value gives 0 µA.
- R10: fault_o follows fault_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| latch_i | input | 1 | Frame latch strobe, rising-edge active |
| sdin_i | input | 1 | Serial data in |
| clear_i | input | 1 | Asynchronous clear to zero scale, active high |
| fault_i | input | 1 | Fault indication from the analog side |
| code_o | output | DATA_W | Output code to the converter |
| range_o | output | 3 | Selected output range |
| loop_ua_o | output | 15 | Nominal loop current in µA |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Serial output enable (low = high impedance) |
| fault_o | output | 1 | Fault flag passed through |

## Verification
Every result that comes from a serial pin appears at the outputs three system clocks after the pin edge. That delay is two synchroniser stages plus the register that acts on the detected edge. The serial output follows a falling serial-clock edge with the same delay. The bench holds each pin level for six system clocks and compares its model with the outputs only once four clocks have passed since the last pin change, so it never samples inside the pipeline delay. The clear and fault paths have no register at all, so they are checked one nanosecond after the pin moves.

// File: rtl/ldf_pkg.sv
package ldf_pkg;
  localparam int FRAME_W = 24;
  localparam int REG_W   = 16;
  localparam int UA_W    = 15;

  localparam logic [7:0] ADR_NOP  = 8'h00;
  localparam logic [7:0] ADR_DATA = 8'h01;
  localparam logic [7:0] ADR_READ = 8'h02;
  localparam logic [7:0] ADR_CTRL = 8'h55;

  localparam logic [2:0] RNG_4_20 = 3'b101;
  localparam logic [2:0] RNG_0_20 = 3'b110;
  localparam logic [2:0] RNG_0_24 = 3'b111;

  typedef struct packed {
    logic       daisy;
    logic [2:0] range;
  } ctrl_t;

  // bottom of the selected range in microamps
  function automatic logic [UA_W-1:0] range_low_ua(logic [2:0] rng);
    return (rng == RNG_4_20) ? UA_W'(4000) : '0;
  endfunction

  // width of the selected range in microamps
  function automatic logic [UA_W-1:0] range_span_ua(logic [2:0] rng);
    case (rng)
      RNG_4_20: return UA_W'(16000);
      RNG_0_20: return UA_W'(20000);
      RNG_0_24: return UA_W'(24000);
      default:  return '0;
    endcase
  endfunction

  // nominal loop current for a left-justified 16-bit code
  function automatic logic [UA_W-1:0] loop_ua(logic [REG_W-1:0] code16, logic [2:0] rng);
    logic [31:0] prod;
    logic [31:0] sum;
    prod = {16'd0, code16} * {17'd0, range_span_ua(rng)};
    sum  = {17'd0, range_low_ua(rng)} + {16'd0, prod[31:16]};
    return sum[UA_W-1:0];
  endfunction
endpackage

// File: rtl/ldf_sync.sv
module ldf_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '{default: '0};
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ldf_rise.sv
module ldf_rise #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/ldf_shift.sv
module ldf_shift #(
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [FW-1:0] frame_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       frame_o <= '0;
    else if (shift_i) frame_o <= {frame_o[FW-2:0], bit_i};
  end
endmodule

// File: rtl/ldf_regs.sv
module ldf_regs
  import ldf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               fault_i,
  output logic [DATA_W-1:0]  data_o,
  output ctrl_t              ctrl_o,
  output logic               is_read_o,
  output logic               rb_load_o,
  output logic               wr_data_o,
  output logic               wr_ctrl_o,
  output logic [FRAME_W-1:0] rb_word_o
);
  localparam int PAD = REG_W - DATA_W;

  logic [7:0]       addr;
  logic [REG_W-1:0] payload;
  logic [REG_W-1:0] data16;
  logic [REG_W-1:0] sel_val;

  assign addr    = frame_i[FRAME_W-1 -: 8];
  assign payload = frame_i[REG_W-1:0];

  assign is_read_o = (addr == ADR_READ);
  assign rb_load_o = load_i && is_read_o;
  assign wr_data_o = load_i && (addr == ADR_DATA);
  assign wr_ctrl_o = load_i && (addr == ADR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      ctrl_o <= '0;
    end else begin
      if (wr_data_o) data_o <= payload[REG_W-1 -: DATA_W];
      if (wr_ctrl_o) ctrl_o <= ctrl_t'(payload[3:0]);
    end
  end

  assign data16 = REG_W'(data_o) << PAD;

  always_comb begin
    case (payload[1:0])
      2'b00:   sel_val = {15'd0, fault_i};
      2'b01:   sel_val = data16;
      2'b10:   sel_val = {12'd0, ctrl_o};
      default: sel_val = '0;
    endcase
  end

  assign rb_word_o = {8'h00, sel_val};
endmodule

// File: rtl/ldf_readout.sv
module ldf_readout #(
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall_i,
  input  logic          latch_i,
  input  logic          rb_load_i,
  input  logic [FW-1:0] rb_word_i,
  input  logic          daisy_i,
  input  logic          tail_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic          rb_active_o
);
  logic [FW-1:0] rb_q;
  logic          dc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_active_o <= 1'b0;
      rb_q        <= '0;
      dc_q        <= 1'b0;
    end else begin
      if (rb_load_i)    rb_active_o <= 1'b1;
      else if (latch_i) rb_active_o <= 1'b0;

      if (rb_load_i)                rb_q <= rb_word_i;
      else if (fall_i && rb_active_o) rb_q <= {rb_q[FW-2:0], 1'b0};

      if (fall_i) dc_q <= tail_i;
    end
  end

  assign sdo_o    = rb_active_o ? rb_q[FW-1] : dc_q;
  assign sdo_oe_o = rb_active_o || daisy_i;
endmodule

// File: rtl/loop_dac_front.sv
module loop_dac_front
  import ldf_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              latch_i,
  input  logic              sdin_i,
  input  logic              clear_i,
  input  logic              fault_i,
  output logic [DATA_W-1:0] code_o,
  output logic [2:0]        range_o,
  output logic [UA_W-1:0]   loop_ua_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              fault_o
);
  localparam int PAD = REG_W - DATA_W;

  logic [2:0]         pin_lvl;
  logic [2:0]         edge_rise;
  logic               sclk_rise, sclk_fall, latch_rise, sdin_lvl;
  logic [FRAME_W-1:0] frame;
  logic [DATA_W-1:0]  data_q;
  ctrl_t              ctrl;
  logic               is_read, rb_load, wr_data, wr_ctrl, rb_active;
  logic [FRAME_W-1:0] rb_word;
  logic [REG_W-1:0]   code16;

  ldf_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({sdin_i, latch_i, sclk_i}),
    .sync_o(pin_lvl)
  );

  // bit 2 watches the inverted serial clock so its rise is a falling edge
  ldf_rise #(.W(3)) u_rise (
    .clk(clk), .rst_n(rst_n),
    .lvl_i({~pin_lvl[0], pin_lvl[1], pin_lvl[0]}),
    .rise_o(edge_rise)
  );

  assign sclk_rise  = edge_rise[0];
  assign latch_rise = edge_rise[1];
  assign sclk_fall  = edge_rise[2];
  assign sdin_lvl   = pin_lvl[2];

  ldf_shift #(.FW(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_i(sclk_rise), .bit_i(sdin_lvl),
    .frame_o(frame)
  );

  ldf_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .load_i(latch_rise), .frame_i(frame), .fault_i(fault_i),
    .data_o(data_q), .ctrl_o(ctrl),
    .is_read_o(is_read), .rb_load_o(rb_load),
    .wr_data_o(wr_data), .wr_ctrl_o(wr_ctrl),
    .rb_word_o(rb_word)
  );

  ldf_readout #(.FW(FRAME_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .fall_i(sclk_fall), .latch_i(latch_rise),
    .rb_load_i(rb_load), .rb_word_i(rb_word),
    .daisy_i(ctrl.daisy), .tail_i(frame[FRAME_W-1]),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .rb_active_o(rb_active)
  );

  // clear acts without a clock edge
  assign code_o    = clear_i ? '0 : data_q;
  assign range_o   = ctrl.range;
  assign code16    = REG_W'(code_o) << PAD;
  assign loop_ua_o = loop_ua(code16, ctrl.range);
  assign fault_o   = fault_i;
endmodule

// File: rtl/ldf_checker.sv
module ldf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        latch_rise,
  input logic        sclk_fall,
  input logic        is_read,
  input logic        rb_load,
  input logic        wr_data,
  input logic        wr_ctrl,
  input logic        daisy,
  input logic        rb_active,
  input logic        tail_bit,
  input logic        clear_i,
  input logic [15:0] code_o,
  input logic [2:0]  range_o,
  input logic [14:0] loop_ua_o,
  input logic        sdo_o,
  input logic        sdo_oe_o
);
  assert_oe_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_rise && !is_read && !wr_ctrl && !daisy) |=> !sdo_oe_o);

  assert_rb_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rb_load |=> (sdo_oe_o && sdo_o == 1'b0));

  assert_code_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_data && !clear_i) |=> (clear_i || $stable(code_o)));

  assert_range_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(range_o));

  assert_loop_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
    loop_ua_o <= 15'd24000);

  assert_daisy_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && daisy && !rb_active && !latch_rise && !rb_load) |=> (sdo_o == $past(tail_bit)));

  assert_clear_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && range_o == 3'b101) |-> (loop_ua_o == 15'd4000));
endmodule

bind loop_dac_front ldf_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .latch_rise(latch_rise), .sclk_fall(sclk_fall),
  .is_read(is_read), .rb_load(rb_load),
  .wr_data(wr_data), .wr_ctrl(wr_ctrl),
  .daisy(ctrl.daisy), .rb_active(rb_active),
  .tail_bit(frame[23]), .clear_i(clear_i),
  .code_o(16'(code_o)), .range_o(range_o), .loop_ua_o(loop_ua_o),
  .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
);

// File: tb/tb_loop_dac_front.sv
`timescale 1ns/1ps
module tb_loop_dac_front;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0, sclk = 0, latch = 0, sdin = 0, clear = 0, fault = 0;
  logic [DW-1:0] code;
  logic [2:0]    range_sel;
  logic [14:0]   loop_ua;
  logic          sdo, sdo_oe, fault_out;

  always #10 clk = ~clk;

  loop_dac_front #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .latch_i(latch), .sdin_i(sdin),
    .clear_i(clear), .fault_i(fault), .code_o(code), .range_o(range_sel),
    .loop_ua_o(loop_ua), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .fault_o(fault_out)
  );

  int checks = 0, errors = 0, cyc = 0, last_chg = 0;
  bit done = 0, summary_done = 0;

  // behavioural model state
  bit          hist[$];
  bit          rbq[$];
  bit          rb_act = 0, m_dc = 0, m_daisy = 0;
  logic [15:0] m_data16 = 0;
  logic [2:0]  m_range = 0;

  always @(posedge clk) cyc = cyc + 1;

  function automatic int lo_ua(logic [2:0] r);
    return (r == 3'b101) ? 4000 : 0;
  endfunction

  function automatic int span_ua(logic [2:0] r);
    if (r == 3'b101) return 16000;
    if (r == 3'b110) return 20000;
    if (r == 3'b111) return 24000;
    return 0;
  endfunction

  function automatic int exp_code16();
    return clear ? 0 : int'(m_data16);
  endfunction

  function automatic int exp_loop();
    return lo_ua(m_range) + (exp_code16() * span_ua(m_range)) / 65536;
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic finish_up();
    if (!summary_done) begin
      summary_done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // compare the model with the outputs on every settled clock
  always @(negedge clk) begin
    if (rst_n && !done && (cyc - last_chg) >= 4) begin
      chk(clear ? "R8" : "R2", "code_o", int'(code), exp_code16() >> (16 - DW));
      chk("R3", "range_o", int'(range_sel), int'(m_range));
      chk("R9", "loop_ua_o", int'(loop_ua), exp_loop());
      chk("R6", "sdo_oe_o", int'(sdo_oe), int'(rb_act || m_daisy));
      if (sdo_oe)
        chk(rb_act ? "R5" : "R7", "sdo_o", int'(sdo), rb_act ? int'(rbq[0]) : int'(m_dc));
      chk("R10", "fault_o", int'(fault_out), int'(fault));
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic model_latch();
    logic [23:0] f;
    logic [15:0] v;
    logic [15:0] mask;
    mask = 16'hFFFF << (16 - DW);
    for (int i = 0; i < 24; i++) f[23-i] = hist[hist.size()-24+i];
    if (f[23:16] == 8'h02) begin
      case (f[1:0])
        2'b00:   v = {15'd0, fault};
        2'b01:   v = m_data16;
        2'b10:   v = {12'd0, m_daisy, m_range};
        default: v = 16'd0;
      endcase
      rbq.delete();
      for (int i = 23; i >= 0; i--) rbq.push_back(i < 16 ? v[i] : 1'b0);
      rb_act = 1;
    end else begin
      rb_act = 0;
      if (f[23:16] == 8'h01) m_data16 = f[15:0] & mask;
      if (f[23:16] == 8'h55) begin
        m_range = f[2:0];
        m_daisy = f[3];
      end
    end
  endtask

  task automatic clock_bit(bit b, output bit seen);
    @(posedge clk); #2; sdin = b; last_chg = cyc;
    idle(6); #5; seen = sdo;
    @(posedge clk); #2; sclk = 1; last_chg = cyc; hist.push_back(b);
    idle(6);
    @(posedge clk); #2; sclk = 0; last_chg = cyc;
    m_dc = hist[hist.size()-24];
    if (rb_act) begin
      void'(rbq.pop_front());
      rbq.push_back(1'b0);
    end
    idle(6);
  endtask

  task automatic shift_word(logic [23:0] w, output logic [23:0] seen);
    bit s;
    for (int i = 23; i >= 0; i--) begin
      clock_bit(w[i], s);
      seen[i] = s;
    end
  endtask

  task automatic pulse_latch();
    @(posedge clk); #2; latch = 1; last_chg = cyc; model_latch();
    idle(6);
    @(posedge clk); #2; latch = 0; last_chg = cyc;
    idle(6); #5;
  endtask

  task automatic frame(logic [23:0] w, output logic [23:0] seen);
    shift_word(w, seen);
    pulse_latch();
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: requirement any, actual running expected finished");
      finish_up();
    end
  end

  initial begin
    logic [23:0] s, s1, s2;
    for (int i = 0; i < 24; i++) hist.push_back(1'b0);
    idle(5); #2; rst_n = 1; last_chg = cyc;
    idle(6); #5;
    chk("R1", "reset code", int'(code), 0);
    chk("R1", "reset range", int'(range_sel), 0);
    chk("R1", "reset loop", int'(loop_ua), 0);
    chk("R1", "reset sdo_oe", int'(sdo_oe), 0);

    frame(24'h01_8000, s);
    chk("R2", "data write", int'(code), 'h8000);
    chk("R9", "loop with range off", int'(loop_ua), 0);

    frame(24'h55_0005, s);
    chk("R3", "range 4-20", int'(range_sel), 5);
    chk("R9", "mid 4-20", int'(loop_ua), 12000);
    frame(24'h55_0006, s);
    chk("R9", "mid 0-20", int'(loop_ua), 10000);
    frame(24'h55_0007, s);
    chk("R9", "mid 0-24", int'(loop_ua), 12000);
    frame(24'h01_FFFF, s);
    chk("R2", "full code", int'(code), 'hFFFF);
    chk("R9", "full 0-24", int'(loop_ua), 23999);

    frame(24'h33_1234, s);
    chk("R4", "unknown addr code", int'(code), 'hFFFF);
    chk("R4", "unknown addr range", int'(range_sel), 7);
    frame(24'h00_0000, s);
    chk("R4", "no-op code", int'(code), 'hFFFF);
    chk("R4", "no-op range", int'(range_sel), 7);

    @(posedge clk); #2; clear = 1; last_chg = cyc; #1;
    chk("R8", "clear code", int'(code), 0);
    chk("R8", "clear loop 0-24", int'(loop_ua), 0);
    idle(6);
    frame(24'h55_0005, s);
    chk("R8", "clear loop 4-20", int'(loop_ua), 4000);
    @(posedge clk); #2; clear = 0; last_chg = cyc; #1;
    chk("R8", "code after clear", int'(code), 'hFFFF);
    chk("R9", "full 4-20", int'(loop_ua), 19999);
    idle(6);

    frame(24'h02_0001, s);
    chk("R5", "oe after read cmd", int'(sdo_oe), 1);
    frame(24'h00_0000, s);
    chk("R5", "data readback", int'(s), 'h00FFFF);
    chk("R6", "oe after no-op", int'(sdo_oe), 0);

    @(posedge clk); #2; fault = 1; last_chg = cyc; #1;
    chk("R10", "fault pass", int'(fault_out), 1);
    idle(6);
    frame(24'h02_0002, s);
    frame(24'h02_0000, s);
    chk("R5", "control readback", int'(s), 'h000005);
    frame(24'h00_0000, s);
    chk("R5", "status readback", int'(s), 'h000001);
    chk("R6", "oe released", int'(sdo_oe), 0);

    frame(24'h55_000D, s);
    chk("R7", "oe in pass-through", int'(sdo_oe), 1);
    shift_word(24'h01_1234, s1);
    shift_word(24'h01_4321, s2);
    pulse_latch();
    chk("R7", "first delayed frame", int'(s1), 'h55000D);
    chk("R7", "second delayed frame", int'(s2), 'h011234);
    chk("R2", "code after chain", int'(code), 'h4321);
    frame(24'h55_0005, s);
    chk("R6", "oe after pass-through off", int'(sdo_oe), 0);

    done = 1;
    finish_up();
  end
endmodule